// File: doc/BRIEF.md
# Microsecond Free-Running Timer with Coherent Byte Reads

This block keeps a 12-bit up-counter that advances once per microsecond and never stops. The microsecond rate comes from a prescaler that divides the system clock by a parameter, so the counter moves by one on every `TICK_DIV`-th clock. When the count passes its top value it wraps to zero.

Software on an 8-bit bus reads the count through two byte ports. A read of the low port returns the low eight bits and, in the same clock edge, copies the upper four bits into a holding register. A later read of the high port returns that held copy rather than the live bits. A low read followed by a high read therefore always gives one consistent 12-bit value, even if the count carried into the upper bits between the two reads. Two periodic interrupt requests come from the counter. The fast request pulses each time bit 6 goes from 0 to 1, which is every 128 ticks. The slow request pulses each time bit 9 goes from 0 to 1, which is every 1024 ticks.

Top module: `usec_timer`

## Requirements
- R1: Reset is synchronous and active-low. During reset and afterwards, the count and the held upper nibble are zero until something changes them, both interrupt outputs are 0, and `rd_data` is 0.
- R2: After reset is released, the count goes up by exactly one every `TICK_DIV` clocks. After n rising edges with reset high, the count is floor(n / `TICK_DIV`) modulo 4096.
- R3: The count wraps from 0xFFF to 0x000. The wrap raises neither interrupt output.
- R4: A strobe to address 0x24 (`LO_ADDR`) puts count bits [7:0] on `rd_data` at the next clock edge. At that same edge, count bits [11:8] are copied into the held nibble.
- R5: A strobe to address 0x25 (`HI_ADDR`) puts the held nibble on `rd_data` bits [3:0] at the next edge, with bits [7:4] set to 0. The live upper count bits play no part in this result.
- R6: A strobe to the high address, or to any other address except 0x24, leaves the held nibble unchanged. A strobe to any address other than 0x24 or 0x25 returns 0.
- R7: `irq_fast` goes high for exactly one clock, in the clock after the count steps to a value whose bit 6 is 1 and was 0 before. At no other time is it high.
- R8: `irq_slow` goes high for exactly one clock, in the clock after the count steps to a value whose bit 9 is 1 and was 0 before. At no other time is it high.
- R9: A low-port strobe sampled on the same edge as a count step captures the count value from before the step, in both the returned low byte and the held nibble.
- R10: `rd_data` keeps its value in every clock that has no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_stb | input | 1 | Read strobe, one clock per access |
| rd_addr | input | 8 | Address of the register being read |
| rd_data | output | 8 | Read result, valid one clock after the strobe |
| irq_fast | output | 1 | One-clock pulse on each 0-to-1 change of count bit 6 |
| irq_slow | output | 1 | One-clock pulse on each 0-to-1 change of count bit 9 |

## Verification
The hard case is a low-port read that lands on the same edge as the count step carrying 0x1FF to 0x200. At that edge, the snapshot, the carry into the upper nibble and the slow interrupt all happen together. The bench counts clock edges on its own to place the strobe on that exact tick edge. It then expects 0xFF from the low port, a held nibble of 1, and `irq_slow` high in the same sample. The read at the wrap from 0xFFF to 0x000 is provoked the same way. There the bench expects a held nibble of 0xF, with no interrupt at all.

// File: rtl/usec_timer_pkg.sv
// Package: shared types for the microsecond timer.
// Assumes: a byte-wide read bus; the decoder maps each access to one of three kinds.
package usec_timer_pkg;

    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_LO   = 2'd1,
        RSEL_HI   = 2'd2
    } rd_sel_e;

    // Sorts one bus access into the low port, the high port or an unmapped address.
    function automatic rd_sel_e decode_rd(input logic stb, input logic [7:0] addr,
                                          input logic [7:0] lo_a, input logic [7:0] hi_a);
        if (!stb)           return RSEL_NONE;
        else if (addr == lo_a) return RSEL_LO;
        else if (addr == hi_a) return RSEL_HI;
        else                return RSEL_NONE;
    endfunction

endpackage

// File: rtl/usec_timer_prescale.sv
// Module: divides the system clock down to a one-clock tick enable.
// Assumes: TICK_DIV >= 1; with TICK_DIV == 1 the tick is high in every clock.
module usec_timer_prescale #(
    parameter int TICK_DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (TICK_DIV > 1) begin : g_div
            localparam int DIV_W = $clog2(TICK_DIV);
            localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);
            logic [DIV_W-1:0] div_q;

            // Count clocks from 0 to TICK_DIV-1, then start over.
            always_ff @(posedge clk) begin
                if (!rst_n)             div_q <= '0;
                else if (div_q == LAST) div_q <= '0;
                else                    div_q <= div_q + 1'b1;
            end

            assign tick = (div_q == LAST);

            // R2: two ticks never come in back-to-back clocks
            p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end else begin : g_pass
            assign tick = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/usec_timer_edge_irq.sv
// Module: sends a one-clock request when a watched count bit goes from 0 to 1.
// Assumes: cur_bit is the bit now held; nxt_bit is the value it takes on the next step.
module usec_timer_edge_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic cur_bit,
    input  logic nxt_bit,
    output logic irq
);
    // Register a pulse for the clock after the bit rises.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= step & ~cur_bit & nxt_bit;
    end

    // R7/R8: each request lasts a single clock
    p_irq_one_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

// File: rtl/usec_timer_counter.sv
// Module: the free-running count plus the two interrupt edge detectors.
// Assumes: tick is a one-clock enable; FAST_BIT and SLOW_BIT lie below CNT_W.
module usec_timer_counter #(
    parameter int CNT_W    = 12,
    parameter int FAST_BIT = 6,
    parameter int SLOW_BIT = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             irq_fast,
    output logic             irq_slow
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] count_nxt;
    logic [1:0]       irq_vec;

    assign count_nxt = count + ONE;

    // Step the count on each tick; it wraps on overflow.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (tick) count <= count_nxt;
    end

    generate
        for (genvar gi = 0; gi < 2; gi++) begin : g_irq
            localparam int POS = (gi == 0) ? FAST_BIT : SLOW_BIT;
            usec_timer_edge_irq u_edge (
                .clk     (clk),
                .rst_n   (rst_n),
                .step    (tick),
                .cur_bit (count[POS]),
                .nxt_bit (count_nxt[POS]),
                .irq     (irq_vec[gi])
            );
        end
    endgenerate

    assign irq_fast = irq_vec[0];
    assign irq_slow = irq_vec[1];

    // R2: a tick moves the count by exactly one
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> count == $past(count) + ONE);
    // R2: without a tick the count holds
    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));
    // R7: the fast request is raised only when bit 6 has just become 1
    p_fast_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast |-> (count[FAST_BIT] && count[FAST_BIT-1:0] == '0));
    // R8: the slow request is raised only when bit 9 has just become 1
    p_slow_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_slow |-> (count[SLOW_BIT] && count[SLOW_BIT-1:0] == '0));
    // R3: nothing is raised when the count wraps to zero
    p_wrap_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !(irq_fast || irq_slow));
endmodule

// File: rtl/usec_timer_rdport.sv
// Module: byte read ports; a low read captures the upper bits for a later high read.
// Assumes: CNT_W is between 9 and 16, so the upper part fits in the high byte.
module usec_timer_rdport
    import usec_timer_pkg::*;
#(
    parameter int         CNT_W   = 12,
    parameter logic [7:0] LO_ADDR = 8'h24,
    parameter logic [7:0] HI_ADDR = 8'h25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_stb,
    input  logic [7:0]       rd_addr,
    input  logic [CNT_W-1:0] count,
    output logic [7:0]       rd_data
);
    localparam int HI_W = CNT_W - 8;

    rd_sel_e         sel;
    logic [HI_W-1:0] hi_hold;

    assign sel = decode_rd(rd_stb, rd_addr, LO_ADDR, HI_ADDR);

    // On a low read, keep the upper count bits for a later high read.
    always_ff @(posedge clk) begin
        if (!rst_n)             hi_hold <= '0;
        else if (sel == RSEL_LO) hi_hold <= count[CNT_W-1:8];
    end

    // Load the read result on each strobe and keep it until the next strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_stb) begin
            unique case (sel)
                RSEL_LO: rd_data <= count[7:0];
                RSEL_HI: rd_data <= {{(8-HI_W){1'b0}}, hi_hold};
                default: rd_data <= '0;
            endcase
        end
    end

    // R5: the unused top bits of a high read are zero
    p_hi_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_addr == HI_ADDR) |=> rd_data[7:HI_W] == '0);
    // R6: the held nibble changes only on a low read
    p_hold_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && rd_addr == LO_ADDR) |=> $stable(hi_hold));
    // R10: the read result holds while there is no strobe
    p_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));
endmodule

// File: rtl/usec_timer.sv
// Module: top of the microsecond free-running timer.
// Assumes: the clock runs at TICK_DIV MHz; reads are single-clock strobes.
module usec_timer #(
    parameter int         TICK_DIV = 250,
    parameter int         CNT_W    = 12,
    parameter int         FAST_BIT = 6,
    parameter int         SLOW_BIT = 9,
    parameter logic [7:0] LO_ADDR  = 8'h24,
    parameter logic [7:0] HI_ADDR  = 8'h25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_stb,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       irq_fast,
    output logic       irq_slow
);
    logic             tick;
    logic [CNT_W-1:0] count;

    usec_timer_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    usec_timer_counter #(.CNT_W(CNT_W), .FAST_BIT(FAST_BIT), .SLOW_BIT(SLOW_BIT)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .count    (count),
        .irq_fast (irq_fast),
        .irq_slow (irq_slow)
    );

    usec_timer_rdport #(.CNT_W(CNT_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb),
        .rd_addr (rd_addr),
        .count   (count),
        .rd_data (rd_data)
    );

    // R1: the first clock after reset shows quiet outputs
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (rd_data == 8'h00 && !irq_fast && !irq_slow));
endmodule

// File: tb/usec_timer_tb_top.sv
// Bench: directed tests with one task per scenario; each task checks its own results.
// It counts clock edges since reset on its own to predict the count.
module usec_timer_tb_top;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_addr = 8'h00;
    logic [7:0] rd_data;
    logic       irq_fast, irq_slow;

    int  edges = 0;
    int  n_chk = 0;
    int  n_bad = 0;
    bit  mon_en = 1'b0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    usec_timer #(.TICK_DIV(DIV)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_stb   (rd_stb),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .irq_fast (irq_fast),
        .irq_slow (irq_slow)
    );

    // Count rising edges since reset was released.
    always @(posedge clk) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (edges=%0d)", req, act, exp, edges);
        end
    endtask

    // R7/R8/R3: compare the interrupt outputs with the predicted count in every clock.
    always @(negedge clk) begin
        if (mon_en) begin
            int c;
            bit step;
            c    = (edges / DIV) % 4096;
            step = (edges > 0) && (edges % DIV == 0);
            check("R7 irq_fast", int'(irq_fast), int'(step && (c % 128 == 64)));
            check("R8 irq_slow", int'(irq_slow), int'(step && (c % 1024 == 512)));
        end
    end

    task automatic do_read(input logic [7:0] a, output int d, output int cnt);
        cnt     = (edges / DIV) % 4096;
        rd_stb  = 1'b1;
        rd_addr = a;
        @(negedge clk);
        d       = int'(rd_data);
        rd_stb  = 1'b0;
        rd_addr = 8'h00;
    endtask

    task automatic wait_to(input int n);
        while (edges < n) @(negedge clk);
        if (edges != n) check("wait alignment", edges, n);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 rd_data in reset", int'(rd_data), 0);
        check("R1 irq_fast in reset", int'(irq_fast), 0);
        check("R1 irq_slow in reset", int'(irq_slow), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        int d, c;
        apply_reset();
        mon_en = 1'b1;
        do_read(8'h25, d, c);
        check("R1 held nibble after reset", d, 0);
        do_read(8'h24, d, c);
        check("R1 count near zero after reset", d, c & 8'hFF);
    endtask

    task automatic t_prescale();
        int d1, c1, d2, c2;
        wait_to(40 * DIV + 1);
        do_read(8'h24, d1, c1);
        check("R2 count value", d1, 40);
        repeat (DIV - 1) @(negedge clk);
        do_read(8'h24, d2, c2);
        check("R2 one step per TICK_DIV clocks", d2, 41);
        check("R10 hold without strobe", int'(rd_data), 41);
        repeat (5) @(negedge clk);
        check("R10 hold after idle clocks", int'(rd_data), 41);
    endtask

    task automatic t_coincide_carry();
        int d, c;
        wait_to(12'h200 * DIV - 1);
        do_read(8'h24, d, c);
        check("R9 low byte before carry", d, 8'hFF);
        check("R9 slow irq same clock", int'(irq_slow), 1);
        do_read(8'h25, d, c);
        check("R9 held nibble before carry", d, 1);
    endtask

    task automatic t_snapshot();
        int d, c;
        wait_to(12'h2F3 * DIV + 1);
        do_read(8'h24, d, c);
        check("R4 low byte", d, 8'hF3);
        wait_to(12'h305 * DIV + 2);
        do_read(8'h25, d, c);
        check("R5 high port gives held nibble, not live", d, 2);
        do_read(8'h26, d, c);
        check("R6 unmapped address reads zero", d, 0);
        do_read(8'h25, d, c);
        check("R6 held nibble after unmapped and high reads", d, 2);
        do_read(8'h24, d, c);
        check("R4 new low read", d, c & 8'hFF);
        do_read(8'h25, d, c);
        check("R4 new snapshot of upper bits", d, 3);
    endtask

    task automatic t_wrap();
        int d, c;
        wait_to(4096 * DIV - 1);
        do_read(8'h24, d, c);
        check("R9 low byte at wrap edge", d, 8'hFF);
        check("R3 no fast irq on wrap", int'(irq_fast), 0);
        check("R3 no slow irq on wrap", int'(irq_slow), 0);
        do_read(8'h25, d, c);
        check("R9 held nibble at wrap edge", d, 4'hF);
        wait_to(4096 * DIV + 16 * DIV + 1);
        do_read(8'h24, d, c);
        check("R3 count restarts from zero", d, 16);
        do_read(8'h25, d, c);
        check("R3 upper bits zero after wrap", d, 0);
    endtask

    task automatic t_mid_reset();
        int d, c;
        wait_to(4096 * DIV + 200 * DIV);
        do_read(8'h24, d, c);
        apply_reset();
        do_read(8'h25, d, c);
        check("R1 held nibble cleared by reset", d, 0);
        do_read(8'h24, d, c);
        check("R1 count cleared by reset", d, 0);
    endtask

    initial begin
        t_reset();
        t_prescale();
        t_coincide_carry();
        t_snapshot();
        t_wrap();
        t_mid_reset();
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule